// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block decides how a small in-order CPU enters and leaves exception handling. Each cycle it looks at a synchronous exception request, an interrupt request and the pipeline context of the instruction involved. It then chooses one event. It computes the return address to save, writes the saved-PC, saved-status and cause registers, and drives a PC redirect. All of these register updates complete in one clock edge, so every result appears on the outputs one cycle after the inputs that caused it.

The status word is 8 bits wide. Bit 7 is the privileged-mode bit, bit 6 is the register bank select, bit 5 is the block bit, bit 4 is a spare flag and bits 3:0 hold the interrupt mask. While the block bit is 1, interrupts are held off unless the core is asleep, and breakpoint exceptions are dropped. Any other exception raised while the block bit is 1 leads to a reset-style restart instead of a trap. A return strobe restores the saved PC and the saved status. Plain status and vector-base writes let software set up the mask, release the block bit and move the vector table.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, the status word is 0xEF (mode, bank and block bits 1, spare 0, mask 0xF), the vector base is 0, the redirect PC is 0xA0000000, and redirect_valid, reset_redirect, irq_taken and exc_taken are all 0.
- R2: For an accepted re-executing exception (exc_kind=0), saved_pc is set as follows:
  - with dly_ctx=0, it becomes cur_pc;
  - with dly_ctx=1 and the branch unconditional (br_cond=0) or taken, it becomes br_pc;
  - with dly_ctx=1, br_cond=1 and br_taken=0, it becomes cur_pc.
- R3: For an accepted completed exception (exc_kind=1) or an accepted interrupt, saved_pc is set as follows:
  - with dly_ctx=0, it becomes nxt_pc;
  - with dly_ctx=1 and the branch unconditional or taken, it becomes br_target;
  - with dly_ctx=1, br_cond=1 and br_taken=0, it becomes nxt_pc.
- R4: An exception taken with the block bit 0 has the following effect one cycle later:
  - exc_taken=1 and redirect_valid=1;
  - redirect_pc is the old vector base plus 0x100;
  - saved_stat holds the old status, and cause holds exc_code;
  - the status word has bits 7, 6 and 5 set to 1 and bits 4:0 unchanged.
- R5: An interrupt is accepted only when irq_level is strictly greater than the status mask, and only when the block bit is 0 or sleep_mode is 1. On acceptance, one cycle later:
  - irq_taken=1;
  - redirect_pc is the old vector base plus 0x600;
  - cause is 0x3E0;
  - saved_stat and status are updated as in R4.
- R6: An interrupt held off by the block bit is accepted in the cycle after a status write that clears the block bit has taken effect. In the cycle of the write itself, it is not accepted.
- R7: When the block bit is 1:
  - an exception with exc_brk=1 is ignored, with no redirect and no register change;
  - any other exception gives, one cycle later, reset_redirect=1, redirect_valid=1, redirect_pc=0xA0000000 and status 0xEF.
- R8: When an exception is accepted in the same cycle as an acceptable interrupt, the exception wins: exc_taken=1, irq_taken=0 and cause=exc_code.
- R9: A return strobe that coincides with no accepted exception or interrupt redirects to saved_pc and loads the status word from saved_stat, one cycle later.
- R10: A vector-base write always takes effect on the next edge; a trap in the same cycle still uses the old base. A status write takes effect on the next edge only when no exception, interrupt, reset redirect or return happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_kind | input | 1 | 0 re-executing, 1 completed |
| exc_brk | input | 1 | Request is a breakpoint trap |
| exc_code | input | 12 | Cause code of the exception |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | 4 | Interrupt priority level |
| cur_pc | input | 32 | PC of the current instruction |
| nxt_pc | input | 32 | PC of the following instruction |
| dly_ctx | input | 1 | Delay-slot context (slot for re-executing, delayed branch for completed) |
| br_pc | input | 32 | PC of the owning delayed branch |
| br_cond | input | 1 | Owning branch is conditional |
| br_taken | input | 1 | Conditional branch condition is met |
| br_target | input | 32 | Branch destination |
| sleep_mode | input | 1 | Core is in sleep or standby |
| rte_strobe | input | 1 | Return from exception |
| stat_wr | input | 1 | Status word write |
| stat_wval | input | 8 | Status write data |
| vbr_wr | input | 1 | Vector base write |
| vbr_wval | input | 32 | Vector base write data |
| redirect_valid | output | 1 | Redirect PC is valid this cycle |
| redirect_pc | output | 32 | Redirect target |
| reset_redirect | output | 1 | Redirect is a reset-style restart |
| irq_taken | output | 1 | An interrupt entry happened |
| exc_taken | output | 1 | An exception entry happened |
| saved_pc | output | 32 | Saved return PC |
| saved_stat | output | 8 | Saved status word |
| stat | output | 8 | Current status word |
| cause | output | 12 | Cause code register |
| vbr | output | 32 | Vector base register |

## Verification
Exception entry and interrupt acceptance can fall in the same cycle. This is the event where the priority order decides the saved state. The random stimulus raises both requests together often, and a directed case does so with an interrupt level above the mask. In each such cycle, exc_taken, irq_taken, cause and the redirect target are compared against a model in the bench that applies the exception-first rule, together with the block-bit and sleep conditions.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int MASK_W = 4;
    localparam int STAT_W = 8;

    typedef enum logic {
        EXC_REEXEC = 1'b0,
        EXC_DONE   = 1'b1
    } exc_kind_e;

    typedef struct packed {
        logic              priv;
        logic              bank;
        logic              block;
        logic              spare;
        logic [MASK_W-1:0] mask;
    } stat_t;

    localparam stat_t STAT_RESET = '{priv: 1'b1, bank: 1'b1, block: 1'b1,
                                     spare: 1'b0, mask: {MASK_W{1'b1}}};

    function automatic stat_t enter_stat(input stat_t s);
        stat_t r;
        r       = s;
        r.priv  = 1'b1;
        r.bank  = 1'b1;
        r.block = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/exc_retpc_sel.sv
module exc_retpc_sel #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] nxt_pc,
    input  logic            dly_ctx,
    input  logic            br_cond,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_pc,
    input  logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] reexec_pc,
    output logic [XLEN-1:0] done_pc
);

    logic branch_goes;

    always_comb begin
        // an unconditional delayed branch always goes
        branch_goes = !br_cond || br_taken;
        reexec_pc   = (dly_ctx && branch_goes) ? br_pc     : cur_pc;
        done_pc     = (dly_ctx && branch_goes) ? br_target : nxt_pc;
    end

endmodule

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
    import exc_entry_pkg::*;
(
    input  logic              irq_req,
    input  logic [MASK_W-1:0] irq_level,
    input  stat_t             cur_stat,
    input  logic              sleep_mode,
    output logic              accept
);

    logic level_ok;
    logic unblocked;

    always_comb begin
        level_ok  = irq_level > cur_stat.mask;
        unblocked = !cur_stat.block || sleep_mode;
        accept    = irq_req && level_ok && unblocked;
    end

endmodule

// File: rtl/exc_entry_core.sv
module exc_entry_core
    import exc_entry_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               CODE_W   = 12,
    parameter logic [XLEN-1:0]  RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0]  EXC_OFS  = 32'h0000_0100,
    parameter logic [XLEN-1:0]  INT_OFS  = 32'h0000_0600,
    parameter logic [CODE_W-1:0] INT_CODE = 12'h3E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              exc_kind,
    input  logic              exc_brk,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_accept,
    input  logic              rte_strobe,
    input  logic              stat_wr,
    input  stat_t             stat_wval,
    input  logic              vbr_wr,
    input  logic [XLEN-1:0]   vbr_wval,
    input  logic [XLEN-1:0]   reexec_pc,
    input  logic [XLEN-1:0]   done_pc,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              reset_redirect,
    output logic              irq_taken,
    output logic              exc_taken,
    output logic [XLEN-1:0]   saved_pc,
    output stat_t             saved_stat,
    output stat_t             stat,
    output logic [CODE_W-1:0] cause,
    output logic [XLEN-1:0]   vbr
);

    typedef struct packed {
        stat_t             stat;
        stat_t             estat;
        logic [XLEN-1:0]   epc;
        logic [CODE_W-1:0] cause;
        logic [XLEN-1:0]   vbr;
        logic [XLEN-1:0]   rpc;
        logic              rvalid;
        logic              rreset;
        logic              itaken;
        logic              etaken;
    } core_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_EXC,
        EV_RESTART,
        EV_IRQ,
        EV_RTE
    } event_e;

    core_t  st_d, st_q;
    event_e ev;
    logic   exc_live;

    // choose one event per cycle: exception, interrupt, return
    always_comb begin
        exc_live = exc_req && !(st_q.stat.block && exc_brk);
        if (exc_live)
            ev = st_q.stat.block ? EV_RESTART : EV_EXC;
        else if (irq_accept)
            ev = EV_IRQ;
        else if (rte_strobe)
            ev = EV_RTE;
        else
            ev = EV_NONE;
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.rreset = 1'b0;
        st_d.itaken = 1'b0;
        st_d.etaken = 1'b0;
        if (vbr_wr)
            st_d.vbr = vbr_wval;
        unique case (ev)
            EV_EXC: begin
                st_d.estat  = st_q.stat;
                st_d.stat   = enter_stat(st_q.stat);
                st_d.epc    = (exc_kind_e'(exc_kind) == EXC_DONE) ? done_pc : reexec_pc;
                st_d.cause  = exc_code;
                st_d.rpc    = st_q.vbr + EXC_OFS;
                st_d.rvalid = 1'b1;
                st_d.etaken = 1'b1;
            end
            EV_RESTART: begin
                st_d.stat   = STAT_RESET;
                st_d.rpc    = RESET_PC;
                st_d.rvalid = 1'b1;
                st_d.rreset = 1'b1;
            end
            EV_IRQ: begin
                st_d.estat  = st_q.stat;
                st_d.stat   = enter_stat(st_q.stat);
                st_d.epc    = done_pc;
                st_d.cause  = INT_CODE;
                st_d.rpc    = st_q.vbr + INT_OFS;
                st_d.rvalid = 1'b1;
                st_d.itaken = 1'b1;
            end
            EV_RTE: begin
                st_d.stat   = st_q.estat;
                st_d.rpc    = st_q.epc;
                st_d.rvalid = 1'b1;
            end
            default: begin
                if (stat_wr)
                    st_d.stat = stat_wval;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat   <= STAT_RESET;
            st_q.estat  <= '0;
            st_q.epc    <= '0;
            st_q.cause  <= '0;
            st_q.vbr    <= '0;
            st_q.rpc    <= RESET_PC;
            st_q.rvalid <= 1'b0;
            st_q.rreset <= 1'b0;
            st_q.itaken <= 1'b0;
            st_q.etaken <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.rvalid;
    assign redirect_pc    = st_q.rpc;
    assign reset_redirect = st_q.rreset;
    assign irq_taken      = st_q.itaken;
    assign exc_taken      = st_q.etaken;
    assign saved_pc       = st_q.epc;
    assign saved_stat     = st_q.estat;
    assign stat           = st_q.stat;
    assign cause          = st_q.cause;
    assign vbr            = st_q.vbr;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                XLEN     = 32,
    parameter int                CODE_W   = 12,
    parameter logic [XLEN-1:0]   RESET_PC = 32'hA000_0000,
    parameter logic [XLEN-1:0]   EXC_OFS  = 32'h0000_0100,
    parameter logic [XLEN-1:0]   INT_OFS  = 32'h0000_0600,
    parameter logic [CODE_W-1:0] INT_CODE = 12'h3E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              exc_kind,
    input  logic              exc_brk,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic [MASK_W-1:0] irq_level,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   nxt_pc,
    input  logic              dly_ctx,
    input  logic [XLEN-1:0]   br_pc,
    input  logic              br_cond,
    input  logic              br_taken,
    input  logic [XLEN-1:0]   br_target,
    input  logic              sleep_mode,
    input  logic              rte_strobe,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wval,
    input  logic              vbr_wr,
    input  logic [XLEN-1:0]   vbr_wval,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              reset_redirect,
    output logic              irq_taken,
    output logic              exc_taken,
    output logic [XLEN-1:0]   saved_pc,
    output logic [STAT_W-1:0] saved_stat,
    output logic [STAT_W-1:0] stat,
    output logic [CODE_W-1:0] cause,
    output logic [XLEN-1:0]   vbr
);

    logic [XLEN-1:0] reexec_pc;
    logic [XLEN-1:0] done_pc;
    logic            irq_accept;
    stat_t           stat_s;
    stat_t           estat_s;

    exc_retpc_sel #(.XLEN(XLEN)) u_retpc (
        .cur_pc    (cur_pc),
        .nxt_pc    (nxt_pc),
        .dly_ctx   (dly_ctx),
        .br_cond   (br_cond),
        .br_taken  (br_taken),
        .br_pc     (br_pc),
        .br_target (br_target),
        .reexec_pc (reexec_pc),
        .done_pc   (done_pc)
    );

    exc_irq_gate u_gate (
        .irq_req    (irq_req),
        .irq_level  (irq_level),
        .cur_stat   (stat_s),
        .sleep_mode (sleep_mode),
        .accept     (irq_accept)
    );

    exc_entry_core #(
        .XLEN     (XLEN),
        .CODE_W   (CODE_W),
        .RESET_PC (RESET_PC),
        .EXC_OFS  (EXC_OFS),
        .INT_OFS  (INT_OFS),
        .INT_CODE (INT_CODE)
    ) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .exc_req        (exc_req),
        .exc_kind       (exc_kind),
        .exc_brk        (exc_brk),
        .exc_code       (exc_code),
        .irq_accept     (irq_accept),
        .rte_strobe     (rte_strobe),
        .stat_wr        (stat_wr),
        .stat_wval      (stat_t'(stat_wval)),
        .vbr_wr         (vbr_wr),
        .vbr_wval       (vbr_wval),
        .reexec_pc      (reexec_pc),
        .done_pc        (done_pc),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .reset_redirect (reset_redirect),
        .irq_taken      (irq_taken),
        .exc_taken      (exc_taken),
        .saved_pc       (saved_pc),
        .saved_stat     (estat_s),
        .stat           (stat_s),
        .cause          (cause),
        .vbr            (vbr)
    );

    assign stat       = stat_s;
    assign saved_stat = estat_s;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_req,
    input logic            exc_kind,
    input logic            dly_ctx,
    input logic            irq_req,
    input logic [3:0]      irq_level,
    input logic            rte_strobe,
    input logic [XLEN-1:0] cur_pc,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic            reset_redirect,
    input logic            irq_taken,
    input logic            exc_taken,
    input logic [XLEN-1:0] saved_pc,
    input logic [7:0]      saved_stat,
    input logic [7:0]      stat
);

    // R2: plain re-executing fault saves its own PC
    a_r2_reexec_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !stat[5] && !exc_kind && !dly_ctx)
        |=> (exc_taken && saved_pc == $past(cur_pc)));

    // R4: entry leaves mode, bank and block bits set
    a_r4_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (stat[7] && stat[6] && stat[5]));

    // R5: an accepted interrupt was above the mask
    a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> ($past(irq_level) > $past(stat[3:0])));

    // R7: restart goes to the fixed address with reset status
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        reset_redirect |-> (redirect_valid && redirect_pc == RESET_PC && stat == 8'hEF));

    // R8: at most one kind of event per cycle
    a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_taken, irq_taken, reset_redirect}));

    // R9: lone return goes to the saved PC and saved status
    a_r9_return: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_strobe && !exc_req && !irq_req)
        |=> (redirect_valid && redirect_pc == $past(saved_pc) && stat == $past(saved_stat)));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_req        (exc_req),
    .exc_kind       (exc_kind),
    .dly_ctx        (dly_ctx),
    .irq_req        (irq_req),
    .irq_level      (irq_level),
    .rte_strobe     (rte_strobe),
    .cur_pc         (cur_pc),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .reset_redirect (reset_redirect),
    .irq_taken      (irq_taken),
    .exc_taken      (exc_taken),
    .saved_pc       (saved_pc),
    .saved_stat     (saved_stat),
    .stat           (stat)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;

    localparam logic [31:0] RST_PC = 32'hA000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        exc_req, exc_kind, exc_brk, irq_req, dly_ctx, br_cond, br_taken;
    logic        sleep_mode, rte_strobe, stat_wr, vbr_wr;
    logic [11:0] exc_code;
    logic [3:0]  irq_level;
    logic [31:0] cur_pc, nxt_pc, br_pc, br_target, vbr_wval;
    logic [7:0]  stat_wval;
    logic        redirect_valid, reset_redirect, irq_taken, exc_taken;
    logic [31:0] redirect_pc, saved_pc, vbr;
    logic [7:0]  saved_stat, stat;
    logic [11:0] cause;

    exc_entry_ctrl uut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [7:0]  m_stat = 8'hEF, m_estat = 0;
    logic [31:0] m_epc = 0, m_vbr = 0, m_rpc = RST_PC;
    logic [11:0] m_cause = 0;
    logic        m_rv = 0, m_rr = 0, m_it = 0, m_et = 0;
    string       evtag;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_reexec(input logic d, input logic c, input logic t,
                                             input logic [31:0] cp, input logic [31:0] bp);
        return (d && (!c || t)) ? bp : cp;
    endfunction

    function automatic logic [31:0] f_done(input logic d, input logic c, input logic t,
                                           input logic [31:0] np, input logic [31:0] tg);
        return (d && (!c || t)) ? tg : np;
    endfunction

    task automatic model();
        logic blk;
        logic [31:0] old_vbr;
        blk = m_stat[5];
        old_vbr = m_vbr;
        m_rv = 0; m_rr = 0; m_it = 0; m_et = 0;
        evtag = "R10";
        if (vbr_wr) m_vbr = vbr_wval;
        if (exc_req && !(blk && exc_brk)) begin
            if (blk) begin
                m_stat = 8'hEF; m_rpc = RST_PC; m_rv = 1; m_rr = 1; evtag = "R7";
            end else begin
                m_estat = m_stat; m_stat = m_stat | 8'hE0;
                m_epc = exc_kind ? f_done(dly_ctx, br_cond, br_taken, nxt_pc, br_target)
                                 : f_reexec(dly_ctx, br_cond, br_taken, cur_pc, br_pc);
                m_cause = exc_code; m_rpc = old_vbr + 32'h100; m_rv = 1; m_et = 1;
                evtag = irq_req ? "R8" : (exc_kind ? "R3" : "R2");
            end
        end else if (irq_req && (irq_level > m_stat[3:0]) && (!blk || sleep_mode)) begin
            m_estat = m_stat; m_stat = m_stat | 8'hE0;
            m_epc = f_done(dly_ctx, br_cond, br_taken, nxt_pc, br_target);
            m_cause = 12'h3E0; m_rpc = old_vbr + 32'h600; m_rv = 1; m_it = 1;
            evtag = "R5";
        end else if (rte_strobe) begin
            m_stat = m_estat; m_rpc = m_epc; m_rv = 1; evtag = "R9";
        end else if (stat_wr) begin
            m_stat = stat_wval;
        end
    endtask

    task automatic step(input string tag);
        string t;
        model();
        t = (tag == "") ? evtag : tag;
        @(posedge clk);
        @(negedge clk);
        chk({t, " stat"}, {24'd0, stat}, {24'd0, m_stat});
        chk({t, " saved_stat"}, {24'd0, saved_stat}, {24'd0, m_estat});
        chk({t, " saved_pc"}, saved_pc, m_epc);
        chk({t, " cause"}, {20'd0, cause}, {20'd0, m_cause});
        chk({t, " vbr"}, vbr, m_vbr);
        chk({t, " flags"}, {28'd0, redirect_valid, reset_redirect, irq_taken, exc_taken},
            {28'd0, m_rv, m_rr, m_it, m_et});
        if (m_rv) chk({t, " redirect_pc"}, redirect_pc, m_rpc);
    endtask

    task automatic idle();
        exc_req = 0; exc_kind = 0; exc_brk = 0; exc_code = 12'h0A0;
        irq_req = 0; irq_level = 0; dly_ctx = 0; br_cond = 0; br_taken = 0;
        sleep_mode = 0; rte_strobe = 0; stat_wr = 0; stat_wval = 0;
        vbr_wr = 0; vbr_wval = 0;
        cur_pc = 32'h1000; nxt_pc = 32'h1002; br_pc = 32'h0FFE; br_target = 32'h2000;
    endtask

    task automatic unblock(input logic [7:0] v);
        idle(); stat_wr = 1; stat_wval = v; step("R10");
        idle();
    endtask

    task automatic combo(input string tag, input logic k, input logic d, input logic c,
                         input logic t, input logic [31:0] exp);
        unblock(8'h80);
        exc_req = 1; exc_kind = k; dly_ctx = d; br_cond = c; br_taken = t;
        exc_code = 12'h1C0;
        step(tag);
        chk({tag, " combo saved_pc"}, saved_pc, exp);
        idle();
    endtask

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 stat", {24'd0, stat}, 32'hEF);
        chk("R1 vbr", vbr, 32'h0);
        chk("R1 redirect_pc", redirect_pc, RST_PC);
        chk("R1 flags", {28'd0, redirect_valid, reset_redirect, irq_taken, exc_taken}, 32'h0);

        // R2 and R3: six saved-PC combinations
        combo("R2 plain",          0, 0, 0, 0, 32'h1000);
        combo("R2 slot taken",     0, 1, 1, 1, 32'h0FFE);
        combo("R2 slot not taken", 0, 1, 1, 0, 32'h1000);
        combo("R3 plain",          1, 0, 0, 0, 32'h1002);
        combo("R3 branch taken",   1, 1, 1, 1, 32'h2000);
        combo("R3 branch not taken", 1, 1, 1, 0, 32'h1002);

        // R9: return after the last entry
        rte_strobe = 1; step("R9");
        chk("R9 return pc", redirect_pc, 32'h1002);
        idle();

        // R6: held-off interrupt released after the block bit clears
        unblock(8'hA0);
        irq_req = 1; irq_level = 5; step("R6");
        chk("R6 held while blocked", {31'd0, irq_taken}, 32'd0);
        stat_wr = 1; stat_wval = 8'h80; step("R6");
        chk("R6 not in write cycle", {31'd0, irq_taken}, 32'd0);
        stat_wr = 0; step("R6");
        chk("R6 taken after release", {31'd0, irq_taken}, 32'd1);
        idle();

        // R5: sleep override while blocked, and strict level compare
        sleep_mode = 1; irq_req = 1; irq_level = 3; step("R5");
        chk("R5 sleep override", {31'd0, irq_taken}, 32'd1);
        chk("R5 cause", {20'd0, cause}, 32'h3E0);
        unblock(8'h85);
        irq_req = 1; irq_level = 5; step("R5");
        chk("R5 equal level ignored", {31'd0, irq_taken}, 32'd0);
        irq_level = 6; step("R5");
        chk("R5 higher level taken", {31'd0, irq_taken}, 32'd1);
        idle();

        // R7: block bit is 1 here
        exc_req = 1; exc_brk = 1; step("R7");
        chk("R7 breakpoint ignored", {31'd0, redirect_valid}, 32'd0);
        exc_brk = 0; step("R7");
        chk("R7 restart", {31'd0, reset_redirect}, 32'd1);
        chk("R7 restart pc", redirect_pc, RST_PC);
        idle();

        // R8: exception beats interrupt
        unblock(8'h80);
        exc_req = 1; exc_code = 12'h2A0; irq_req = 1; irq_level = 9; step("R8");
        chk("R8 irq lost", {31'd0, irq_taken}, 32'd0);
        chk("R8 cause", {20'd0, cause}, 32'h2A0);
        idle();

        // R10 and R4: new vector base
        vbr_wr = 1; vbr_wval = 32'h8000_0000; step("R10");
        unblock(8'h83);
        exc_req = 1; step("R4");
        chk("R4 vector", redirect_pc, 32'h8000_0100);
        chk("R4 status", {24'd0, stat}, 32'hE3);
        idle();

        // random mix
        for (int n = 0; n < 4000; n++) begin
            idle();
            exc_req    = ($urandom % 6) == 0;
            exc_kind   = $urandom % 2;
            exc_brk    = ($urandom % 4) == 0;
            exc_code   = 12'($urandom);
            irq_req    = ($urandom % 3) == 0;
            irq_level  = 4'($urandom);
            dly_ctx    = $urandom % 2;
            br_cond    = $urandom % 2;
            br_taken   = $urandom % 2;
            sleep_mode = ($urandom % 6) == 0;
            rte_strobe = ($urandom % 10) == 0;
            stat_wr    = ($urandom % 4) == 0;
            stat_wval  = 8'($urandom);
            vbr_wr     = ($urandom % 20) == 0;
            vbr_wval   = $urandom & 32'hFFFF_FF00;
            cur_pc     = $urandom;
            nxt_pc     = cur_pc + 2;
            br_pc      = cur_pc - 2;
            br_target  = $urandom;
            step("");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule